// File: doc/BRIEF.md
# PCIe Legacy and MSI Interrupt Aggregator

This block sits beside a root-complex link controller. It gathers every interrupt event the link reports into one host interrupt line. Legacy INTx events arrive as single-cycle pulses that name one of four lines, and each pulse is either an assert or a deassert. MSI writes arrive as single-cycle pulses that carry a vector number and an 8-bit payload. Power-state-change, flush and other host-level sources are also single-cycle pulses.

Every source lands in a sticky status register. Software clears a status bit by writing 1 to it. Each status register has its own mask register, in which a 1 suppresses that source.

The status is arranged in two levels:
- The primary and secondary status registers hold the link-side events.
- The primary register also carries an MSI-pending bit, which is derived from the unmasked 32-bit MSI status.
- Any unmasked primary or secondary bit raises a core-summary bit in the host-level status register.
- The interrupt output is high whenever any unmasked host-level status bit is set.

Software reaches all registers through a simple word-indexed read/write port. Reads are combinational and writes take effect on the clock edge.

Top module: `pcie_irq_aggregator`

## Requirements
- R1: After reset every status register and the payload register read 0. Every mask register reads all ones over its implemented bits: primary 0x07FFFFFF, secondary 0x00000030, MSI 0xFFFFFFFF, host 0x00FFF0FB. The interrupt output is low.
- R2: An INTx pulse with 2-bit line index n sets primary status bit 16+n when it is an assert and bit 20+n when it is a deassert. The bit is visible one cycle after the pulse.
- R3: Writing a status register clears exactly the bits written as 1 and leaves the other bits unchanged. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R4: An MSI pulse with vector v sets MSI status bit v one cycle later. The payload register then returns the pulse's 8-bit payload, zero-extended.
- R5: Primary bit 24 (MSI pending) is set in the cycle after any MSI status bit whose MSI mask bit is 0 is set. A masked vector does not set it. The bit stays set after the MSI status is cleared, until software clears bit 24 itself.
- R6: Host status bit 16 (core summary) is set in the cycle after any primary bit in [26:0] or secondary bit in [5:4] is set with its mask bit 0. Masked bits do not set it.
- R7: A power-state pulse sets secondary bit 4 and a flush pulse sets secondary bit 5.
- R8: A host source pulse on bit b sets host status bit b only where 0x00FFF0FB has a 1. Bit 17 is the PIO source. The input bit 16 is ignored, because host bit 16 comes only from the core summary.
- R9: The interrupt output is high exactly while some host status bit is set with its host mask bit 0.
- R10: The register map uses word index 0 for primary status, 1 for primary mask, 2 for secondary status, 3 for secondary mask, 4 for MSI status, 5 for MSI mask, 6 for the read-only payload, 7 for host status and 8 for host mask. Mask writes keep only implemented bits. Writes to index 6 are ignored, and indices 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intxValid | input | 1 | INTx event pulse |
| intxDeassert | input | 1 | 1 marks the INTx event as a deassert, 0 as an assert |
| intxIndex | input | 2 | INTx line number (0 to 3) |
| msiValid | input | 1 | MSI write pulse |
| msiVector | input | MSI_IDX_W (5) | MSI vector number |
| msiPayload | input | 8 | MSI message data |
| pwrStateEvt | input | 1 | Power-state-change event pulse |
| flushEvt | input | 1 | Flush event pulse |
| hostSrcEvt | input | 24 | Other host-level source pulses (bit 17 = PIO) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (4) | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| irqOut | output | 1 | Summary interrupt, active high level |

## Verification
The bench builds the block with its defaults: 32 MSI vectors and a 4-bit register index. This makes the whole design small enough to sweep exhaustively. Every MSI vector is sent once with its own payload, and every fourth vector is masked to exercise the pending-bit gating. Each of the four INTx lines is driven in both polarities. All 24 host source bit positions are pulsed and compared against the implemented-bit constant, and all 16 register indices are read at reset.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int REG_W             = 32;
  localparam int INTX_LINES        = 4;
  localparam int INTX_IDX_W        = 2;
  localparam int INTX_ASSERT_LSB   = 16;
  localparam int INTX_DEASSERT_LSB = 20;
  localparam int MSI_PEND_BIT      = 24;
  localparam int SEC_PWR_BIT       = 4;
  localparam int SEC_FLUSH_BIT     = 5;
  localparam int HOST_CORE_BIT     = 16;
  localparam int HOST_PIO_BIT      = 17;
  localparam int HOST_SRC_W        = 24;
  localparam int PAYLOAD_W         = 8;

  localparam logic [REG_W-1:0] PRI_IMPL  = 32'h07FF_FFFF;
  localparam logic [REG_W-1:0] SEC_IMPL  = 32'h0000_0030;
  localparam logic [REG_W-1:0] HOST_IMPL = 32'h00FF_F0FB;

  localparam int A_PRI_STAT  = 0;
  localparam int A_PRI_MASK  = 1;
  localparam int A_SEC_STAT  = 2;
  localparam int A_SEC_MASK  = 3;
  localparam int A_MSI_STAT  = 4;
  localparam int A_MSI_MASK  = 5;
  localparam int A_PAYLOAD   = 6;
  localparam int A_HOST_STAT = 7;
  localparam int A_HOST_MASK = 8;

  typedef struct packed {
    logic priClr;
    logic priMsk;
    logic secClr;
    logic secMsk;
    logic msiClr;
    logic msiMsk;
    logic hostClr;
    logic hostMsk;
  } regStrobe_t;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_PRI_STAT,
    RS_PRI_MASK,
    RS_SEC_STAT,
    RS_SEC_MASK,
    RS_MSI_STAT,
    RS_MSI_MASK,
    RS_PAYLOAD,
    RS_HOST_STAT,
    RS_HOST_MASK
  } rdSel_t;
endpackage

// File: rtl/pirq_w1c_bank.sv
module pirq_w1c_bank #(
  parameter int               WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] setVec,
  input  logic             clrEn,
  input  logic             mskEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] stat,
  output logic [WIDTH-1:0] mask
);
  logic [WIDTH-1:0] clrVec;

  // Event sets are applied after clears so a same-cycle event survives.
  assign clrVec = clrEn ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat <= '0;
      mask <= IMPL;
    end else begin
      stat <= ((stat & ~clrVec) | setVec) & IMPL;
      if (mskEn) mask <= wrData & IMPL;
    end
  end

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|(setVec & IMPL)) |=> ((stat & $past(setVec & IMPL)) == $past(setVec & IMPL)));

  p_clear_only_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    clrEn |=> ((stat & $past(wrData & ~setVec & IMPL)) == '0));
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);
  always_comb begin
    strobe = '0;
    rdSel  = RS_NONE;
    case (regAddr)
      ADDR_W'(A_PRI_STAT):  begin rdSel = RS_PRI_STAT;  strobe.priClr  = regWrEn; end
      ADDR_W'(A_PRI_MASK):  begin rdSel = RS_PRI_MASK;  strobe.priMsk  = regWrEn; end
      ADDR_W'(A_SEC_STAT):  begin rdSel = RS_SEC_STAT;  strobe.secClr  = regWrEn; end
      ADDR_W'(A_SEC_MASK):  begin rdSel = RS_SEC_MASK;  strobe.secMsk  = regWrEn; end
      ADDR_W'(A_MSI_STAT):  begin rdSel = RS_MSI_STAT;  strobe.msiClr  = regWrEn; end
      ADDR_W'(A_MSI_MASK):  begin rdSel = RS_MSI_MASK;  strobe.msiMsk  = regWrEn; end
      ADDR_W'(A_PAYLOAD):   begin rdSel = RS_PAYLOAD; end
      ADDR_W'(A_HOST_STAT): begin rdSel = RS_HOST_STAT; strobe.hostClr = regWrEn; end
      ADDR_W'(A_HOST_MASK): begin rdSel = RS_HOST_MASK; strobe.hostMsk = regWrEn; end
      default:              begin rdSel = RS_NONE; end
    endcase
  end
endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int NUM_MSI   = 32,
  parameter int MSI_IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  intxValid,
  input  logic                  intxDeassert,
  input  logic [INTX_IDX_W-1:0] intxIndex,
  input  logic                  msiValid,
  input  logic [MSI_IDX_W-1:0]  msiVector,
  input  logic [PAYLOAD_W-1:0]  msiPayload,
  input  logic                  pwrStateEvt,
  input  logic                  flushEvt,
  input  logic [HOST_SRC_W-1:0] hostSrcEvt,
  input  regStrobe_t            strobe,
  input  rdSel_t                rdSel,
  input  logic [REG_W-1:0]      wrData,
  output logic [REG_W-1:0]      rdData,
  output logic                  irqOut
);
  logic [REG_W-1:0]     priSet, priStat, priMask;
  logic [REG_W-1:0]     secSet, secStat, secMask;
  logic [REG_W-1:0]     hostSet, hostStat, hostMask;
  logic [NUM_MSI-1:0]   msiSet, msiStat, msiMask;
  logic [PAYLOAD_W-1:0] payload;
  logic                 msiPending;
  logic                 coreSum;

  assign msiPending = |(msiStat & ~msiMask);
  assign coreSum    = (|(priStat & ~priMask)) | (|(secStat & ~secMask));

  always_comb begin
    priSet = '0;
    for (int n = 0; n < INTX_LINES; n++) begin
      if (intxValid && intxIndex == INTX_IDX_W'(n)) begin
        if (intxDeassert) priSet[INTX_DEASSERT_LSB + n] = 1'b1;
        else              priSet[INTX_ASSERT_LSB + n]   = 1'b1;
      end
    end
    priSet[MSI_PEND_BIT] = msiPending;
  end

  always_comb begin
    secSet                = '0;
    secSet[SEC_PWR_BIT]   = pwrStateEvt;
    secSet[SEC_FLUSH_BIT] = flushEvt;
  end

  always_comb begin
    msiSet = '0;
    if (msiValid && (32'(msiVector) < NUM_MSI)) msiSet[msiVector] = 1'b1;
  end

  always_comb begin
    hostSet                = REG_W'(hostSrcEvt);
    hostSet[HOST_CORE_BIT] = coreSum;
  end

  pirq_w1c_bank #(.WIDTH(REG_W), .IMPL(PRI_IMPL)) uPri (
    .clk(clk), .rstN(rstN), .setVec(priSet), .clrEn(strobe.priClr),
    .mskEn(strobe.priMsk), .wrData(wrData), .stat(priStat), .mask(priMask));

  pirq_w1c_bank #(.WIDTH(REG_W), .IMPL(SEC_IMPL)) uSec (
    .clk(clk), .rstN(rstN), .setVec(secSet), .clrEn(strobe.secClr),
    .mskEn(strobe.secMsk), .wrData(wrData), .stat(secStat), .mask(secMask));

  pirq_w1c_bank #(.WIDTH(NUM_MSI), .IMPL({NUM_MSI{1'b1}})) uMsi (
    .clk(clk), .rstN(rstN), .setVec(msiSet), .clrEn(strobe.msiClr),
    .mskEn(strobe.msiMsk), .wrData(wrData[NUM_MSI-1:0]), .stat(msiStat), .mask(msiMask));

  pirq_w1c_bank #(.WIDTH(REG_W), .IMPL(HOST_IMPL)) uHost (
    .clk(clk), .rstN(rstN), .setVec(hostSet), .clrEn(strobe.hostClr),
    .mskEn(strobe.hostMsk), .wrData(wrData), .stat(hostStat), .mask(hostMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         payload <= '0;
    else if (msiValid) payload <= msiPayload;
  end

  assign irqOut = |(hostStat & ~hostMask);

  always_comb begin
    case (rdSel)
      RS_PRI_STAT:  rdData = priStat;
      RS_PRI_MASK:  rdData = priMask;
      RS_SEC_STAT:  rdData = secStat;
      RS_SEC_MASK:  rdData = secMask;
      RS_MSI_STAT:  rdData = REG_W'(msiStat);
      RS_MSI_MASK:  rdData = REG_W'(msiMask);
      RS_PAYLOAD:   rdData = REG_W'(payload);
      RS_HOST_STAT: rdData = hostStat;
      RS_HOST_MASK: rdData = hostMask;
      default:      rdData = '0;
    endcase
  end

  p_intx_assert_r2: assert property (@(posedge clk) disable iff (!rstN)
    (intxValid && !intxDeassert) |=> priStat[INTX_ASSERT_LSB + 32'($past(intxIndex))]);

  p_intx_deassert_r2: assert property (@(posedge clk) disable iff (!rstN)
    (intxValid && intxDeassert) |=> priStat[INTX_DEASSERT_LSB + 32'($past(intxIndex))]);

  p_msi_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    msiValid |=> msiStat[$past(msiVector)]);

  p_payload_r4: assert property (@(posedge clk) disable iff (!rstN)
    msiValid |=> (payload == $past(msiPayload)));

  p_pend_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    msiPending |=> priStat[MSI_PEND_BIT]);

  p_core_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    coreSum |=> hostStat[HOST_CORE_BIT]);

  p_sec_pwr_r7: assert property (@(posedge clk) disable iff (!rstN)
    pwrStateEvt |=> secStat[SEC_PWR_BIT]);

  p_pio_r8: assert property (@(posedge clk) disable iff (!rstN)
    hostSrcEvt[HOST_PIO_BIT] |=> hostStat[HOST_PIO_BIT]);

  p_irq_rise_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(|(hostSet & HOST_IMPL)) || $past(strobe.hostMsk)));
endmodule

// File: rtl/pcie_irq_aggregator.sv
module pcie_irq_aggregator
  import pirq_pkg::*;
#(
  parameter int NUM_MSI = 32,
  parameter int ADDR_W  = 4,
  localparam int MSI_IDX_W = $clog2(NUM_MSI)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  intxValid,
  input  logic                  intxDeassert,
  input  logic [1:0]            intxIndex,
  input  logic                  msiValid,
  input  logic [MSI_IDX_W-1:0]  msiVector,
  input  logic [7:0]            msiPayload,
  input  logic                  pwrStateEvt,
  input  logic                  flushEvt,
  input  logic [23:0]           hostSrcEvt,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  output logic                  irqOut
);
  regStrobe_t strobe;
  rdSel_t     rdSel;

  pirq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .strobe(strobe), .rdSel(rdSel));

  pirq_datapath #(.NUM_MSI(NUM_MSI), .MSI_IDX_W(MSI_IDX_W)) uDp (
    .clk(clk), .rstN(rstN),
    .intxValid(intxValid), .intxDeassert(intxDeassert), .intxIndex(intxIndex),
    .msiValid(msiValid), .msiVector(msiVector), .msiPayload(msiPayload),
    .pwrStateEvt(pwrStateEvt), .flushEvt(flushEvt), .hostSrcEvt(hostSrcEvt),
    .strobe(strobe), .rdSel(rdSel), .wrData(regWrData),
    .rdData(regRdData), .irqOut(irqOut));
endmodule

// File: tb/tb_pcie_irq_aggregator.sv
module tb_pcie_irq_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intxValid = 0, intxDeassert = 0;
  logic [1:0]  intxIndex = 0;
  logic        msiValid = 0;
  logic [4:0]  msiVector = 0;
  logic [7:0]  msiPayload = 0;
  logic        pwrStateEvt = 0, flushEvt = 0;
  logic [23:0] hostSrcEvt = 0;
  logic        regWrEn = 0;
  logic [3:0]  regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic        irqOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  localparam logic [31:0] HOST_IMPL_TB = 32'h00FF_F0FB;

  always #5 clk = ~clk;

  pcie_irq_aggregator dut (
    .clk(clk), .rstN(rstN), .intxValid(intxValid), .intxDeassert(intxDeassert),
    .intxIndex(intxIndex), .msiValid(msiValid), .msiVector(msiVector),
    .msiPayload(msiPayload), .pwrStateEvt(pwrStateEvt), .flushEvt(flushEvt),
    .hostSrcEvt(hostSrcEvt), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkReg(input string tag, input int a, input logic [31:0] exp);
    regAddr = 4'(a);
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    regWrEn = 1; regAddr = 4'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic intx(input int n, input bit deas);
    intxValid = 1; intxIndex = 2'(n); intxDeassert = deas;
    @(negedge clk);
    intxValid = 0; intxDeassert = 0;
  endtask

  task automatic msi(input int v, input logic [7:0] d);
    msiValid = 1; msiVector = 5'(v); msiPayload = d;
    @(negedge clk);
    msiValid = 0;
  endtask

  task automatic clearAll();
    wr(0, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
    tick(1);
    wr(0, 32'hFFFF_FFFF);
    tick(1);
    wr(7, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1: reset state of every register, and R10: unused indices read 0
    chk("R1 irq at reset", 32'(irqOut), 0);
    chkReg("R1 pri stat", 0, 0);
    chkReg("R1 pri mask", 1, 32'h07FF_FFFF);
    chkReg("R1 sec stat", 2, 0);
    chkReg("R1 sec mask", 3, 32'h30);
    chkReg("R1 msi stat", 4, 0);
    chkReg("R1 msi mask", 5, 32'hFFFF_FFFF);
    chkReg("R1 payload", 6, 0);
    chkReg("R1 host stat", 7, 0);
    chkReg("R1 host mask", 8, HOST_IMPL_TB);
    for (int a = 9; a < 16; a++) chkReg("R10 unused index", a, 0);
    rstN = 1;
    tick(1);

    // R2: both polarities on every INTx line
    for (int n = 0; n < 4; n++) begin
      for (int p = 0; p < 2; p++) begin
        intx(n, p[0]);
        chkReg("R2 intx bit", 0, 32'h1 << (p ? 20 + n : 16 + n));
        chkReg("R6 masked pri gives no core", 7, 0);
        wr(0, 32'h1 << (p ? 20 + n : 16 + n));
        chkReg("R3 intx cleared", 0, 0);
      end
    end

    // R3: partial clear, then set and clear of the same bit in one cycle
    intx(0, 0); intx(1, 0);
    wr(0, 32'h0001_0000);
    chkReg("R3 only written bit cleared", 0, 32'h0002_0000);
    intxValid = 1; intxIndex = 0; intxDeassert = 0;
    regWrEn = 1; regAddr = 0; regWrData = 32'h0003_0000;
    @(negedge clk);
    intxValid = 0; regWrEn = 0;
    chkReg("R3 set wins over clear", 0, 32'h0001_0000);
    wr(0, 32'hFFFF_FFFF);

    // R10: mask writes keep implemented bits, payload writes ignored
    wr(8, 32'hFFFE_FFFF);
    chkReg("R10 host mask impl bits", 8, 32'h00FE_F0FB);
    wr(1, 32'hFFFF_FFFF);
    chkReg("R10 pri mask impl bits", 1, 32'h07FF_FFFF);
    wr(1, 32'h0);
    wr(5, 32'h0);
    msi(3, 8'h5A);
    wr(6, 32'h0000_00FF);
    chkReg("R10 payload write ignored", 6, 32'h5A);
    clearAll();

    // R4, R5, R6, R9: sweep every MSI vector, masking every fourth one
    for (int v = 0; v < 32; v++) begin
      logic [7:0] d;
      bit masked;
      d = 8'(v * 37 + 11);
      masked = (v % 4) == 3;
      wr(5, masked ? (32'h1 << v) : 32'h0);
      msi(v, d);
      chkReg("R4 msi status bit", 4, 32'h1 << v);
      chkReg("R4 payload", 6, 32'(d));
      tick(1);
      chkReg("R5 pending bit", 0, masked ? 32'h0 : 32'h0100_0000);
      tick(1);
      chkReg("R6 core summary", 7, masked ? 32'h0 : 32'h0001_0000);
      chk("R9 irq level", 32'(irqOut), masked ? 32'h0 : 32'h1);
      if (!masked && v == 0) begin
        wr(4, 32'h1);
        tick(1);
        chkReg("R5 pending sticky", 0, 32'h0100_0000);
      end
      clearAll();
      chk("R9 irq after clear", 32'(irqOut), 0);
    end

    // R5: clearing bit 24 while MSI still pending re-sets it
    wr(5, 32'h0);
    msi(9, 8'h01);
    tick(1);
    wr(0, 32'h0100_0000);
    chkReg("R5 pending re-sets", 0, 32'h0100_0000);
    clearAll();

    // R7, R6: secondary events and their mask
    pwrStateEvt = 1; @(negedge clk); pwrStateEvt = 0;
    chkReg("R7 power-state bit", 2, 32'h10);
    tick(1);
    chkReg("R6 masked sec no core", 7, 0);
    wr(3, 32'h20);
    tick(1);
    chkReg("R6 unmasked sec core", 7, 32'h0001_0000);
    flushEvt = 1; @(negedge clk); flushEvt = 0;
    chkReg("R7 flush bit", 2, 32'h30);
    wr(3, 32'h30);
    clearAll();

    // R8, R9: sweep every host source bit
    wr(8, 32'h0);
    for (int b = 0; b < 24; b++) begin
      logic [31:0] e;
      e = (b == 16) ? 32'h0 : ((32'h1 << b) & HOST_IMPL_TB);
      hostSrcEvt = 24'h1 << b; @(negedge clk); hostSrcEvt = 0;
      chkReg("R8 host source bit", 7, e);
      chk("R9 irq from host bit", 32'(irqOut), 32'(e != 0));
      wr(7, 32'hFFFF_FFFF);
    end
    hostSrcEvt = 24'h1 << 17; @(negedge clk); hostSrcEvt = 0;
    wr(8, 32'hFFFF_FFFF);
    chk("R9 masked host bit no irq", 32'(irqOut), 0);
    chkReg("R8 PIO bit held", 7, 32'h0002_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule